// File: doc/BRIEF.md
# Serial Differential Converter Readout Controller

This block sits on the host side of a 13-bit differential successive-approximation converter that has a three-wire serial port. When it receives a start request it runs one frame. It lowers the active-low select, waits a setup interval, and then toggles the serial clock through exactly 17 periods. During those periods it collects the converter's output. At the end it raises the select and presents the result as a sign-extended two's-complement word together with a one-cycle done strobe.

All timing is counted in system clocks. The half-period of the serial clock comes from a divider input. That value is forced into a window that respects both the fastest serial clock the converter tolerates and the slowest one that still keeps its held sample intact. The value is captured once per frame. The converter spends the first rising edges acquiring its input and then emits a null bit. The controller throws those bits away and keeps the sign bit and the twelve magnitude bits, most significant first. Between frames the select stays high for a minimum recovery time. A request that arrives during that recovery time is remembered and served as soon as the time has passed.

Top module: `adc_rd_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, `cs_n_o` is 1, `sclk_o` is 0, `done_o` is 0 and `sample_o` is 0.
- R2: Each frame holds exactly 17 rising edges of `sclk_o` while `cs_n_o` is 0. Whenever `cs_n_o` is 1, `sclk_o` is 0.
- R3: Every high phase and every low phase of `sclk_o` inside a frame lasts H system clocks. H is `div_i` clamped to the range [MIN_HALF, MAX_HALF] (28 and 588 by default). H is captured when the frame begins, and changes to `div_i` during the frame have no effect.
- R4: `cs_n_o` is 0 for exactly CS_SETUP system clocks (10 by default) before the first rising edge of `sclk_o`.
- R5: `sdata_i` is captured at rising edges 4 through 16 of the frame. The first captured bit is the sign and is stored as result bit 12. The last captured bit is result bit 0. The values present at rising edges 1 to 3 (acquisition and null bit) and at edge 17 do not affect the result.
- R6: The 13-bit two's-complement result appears on `sample_o` sign-extended to 16 bits, with bits 15..13 equal to bit 12. It appears in the same cycle that `cs_n_o` returns to 1. `done_o` is 1 for exactly that one cycle, and `sample_o` holds its value until the next done.
- R7: Between frames `cs_n_o` stays 1 for at least CS_HIGH system clocks (58 by default). If a start arrives while that interval is running, it is kept, and `cs_n_o` falls after exactly CS_HIGH high cycles.
- R8: A start that arrives while `cs_n_o` is 0 is dropped. After that frame ends, no new frame begins without a new start.
- R9: After reset is released, the recovery interval runs first. A start given in the first cycle out of reset makes `cs_n_o` fall at the (CS_HIGH+1)-th falling system-clock edge after the release, and not sooner.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request for one conversion frame |
| div_i | input | DIV_W (10) | Requested serial clock half-period in system clocks |
| sdata_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low converter select |
| sclk_o | output | 1 | Serial clock to the converter |
| sample_o | output | OUT_W (16) | Sign-extended two's-complement result |
| done_o | output | 1 | One-cycle strobe marking a new result |

## Verification
The converter model drives a code after each falling serial-clock edge. In the discarded slots it places the inverse of the sign bit, so any misalignment or any capture of a non-data bit changes the result. The codes tried are 0, -1, the largest positive and most negative values, and mixed positive and negative patterns. Together they separate a correct sign extension from zero fill, and a correct MSB-first order from a reversed order. The divider is set below the lower limit, inside the window and above the upper limit, which shows that clamping happens on both sides. A change of the divider during a frame and a start given during a frame show that the captured half-period and the drop rule hold. A start given during recovery, and another given right after reset, measure the exact length of the select-high interval.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
    // Serial frame shape of the converter; the controller's behaviour depends on these
    localparam int FRAME_CLKS = 17; // serial clocks per conversion
    localparam int LEAD_RISES = 3;  // rising edges before the sign bit: two acquisition, one null
    localparam int RES_BITS   = 13; // sign plus twelve magnitude bits

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HI,
        ST_LO,
        ST_GAP
    } rd_state_e;
endpackage

// File: rtl/adc_rd_rate.sv
module adc_rd_rate #(
    parameter int DIV_W    = 10,
    parameter int MIN_HALF = 28,
    parameter int MAX_HALF = 588
) (
    input  logic [DIV_W-1:0] div_i,
    output logic [DIV_W-1:0] half_o
);
    localparam logic [DIV_W-1:0] LOW_LIM  = DIV_W'(MIN_HALF);
    localparam logic [DIV_W-1:0] HIGH_LIM = DIV_W'(MAX_HALF);

    // Keep the serial clock between its fastest and slowest permitted rates
    always_comb begin
        if (div_i < LOW_LIM)       half_o = LOW_LIM;
        else if (div_i > HIGH_LIM) half_o = HIGH_LIM;
        else                       half_o = div_i;
    end
endmodule

// File: rtl/adc_rd_shift.sv
module adc_rd_shift #(
    parameter int RES_BITS = 13,
    parameter int OUT_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             shift_en_i,
    input  logic             bit_i,
    output logic [OUT_W-1:0] word_o
);
    logic [RES_BITS-1:0] sreg_d, sreg_q;

    always_comb begin
        sreg_d = sreg_q;
        if (clear_i)         sreg_d = '0;
        else if (shift_en_i) sreg_d = {sreg_q[RES_BITS-2:0], bit_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sreg_q <= '0;
        else        sreg_q <= sreg_d;
    end

    generate
        if (OUT_W > RES_BITS) begin : g_ext
            assign word_o = {{(OUT_W-RES_BITS){sreg_q[RES_BITS-1]}}, sreg_q};
        end else begin : g_same
            assign word_o = OUT_W'(sreg_q);
        end
    endgenerate

    // R5: a shift enters the new bit at the least significant end
    p_shift_lsb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en_i && !clear_i |=> sreg_q[0] == $past(bit_i));
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
    import adc_rd_pkg::*;
#(
    parameter int DIV_W    = 10,
    parameter int MIN_HALF = 28,
    parameter int MAX_HALF = 588,
    parameter int CS_SETUP = 10,
    parameter int CS_HIGH  = 58,
    parameter int OUT_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             sdata_i,
    output logic             cs_n_o,
    output logic             sclk_o,
    output logic [OUT_W-1:0] sample_o,
    output logic             done_o
);
    localparam int TMR_MAX0   = (MAX_HALF > CS_HIGH) ? MAX_HALF : CS_HIGH;
    localparam int TMR_MAX    = (TMR_MAX0 > CS_SETUP) ? TMR_MAX0 : CS_SETUP;
    localparam int TMR_W      = $clog2(TMR_MAX + 1);
    localparam int CNT_W      = $clog2(FRAME_CLKS + 1);
    localparam int FIRST_KEEP = LEAD_RISES + 1;
    localparam int LAST_KEEP  = LEAD_RISES + RES_BITS;

    typedef struct packed {
        rd_state_e        st;
        logic [TMR_W-1:0] tmr;
        logic [CNT_W-1:0] rises;
        logic [DIV_W-1:0] half;
        logic             pend;
        logic             cs_n;
        logic             sclk;
        logic             done;
        logic [OUT_W-1:0] sample;
    } ctrl_s;

    ctrl_s            d, q;
    logic [DIV_W-1:0] half_w;
    logic [OUT_W-1:0] word_w;
    logic             shift_en, clear_sr;
    logic [CNT_W-1:0] rise_nx;

    adc_rd_rate #(.DIV_W(DIV_W), .MIN_HALF(MIN_HALF), .MAX_HALF(MAX_HALF)) u_rate (
        .div_i (div_i),
        .half_o(half_w)
    );

    adc_rd_shift #(.RES_BITS(RES_BITS), .OUT_W(OUT_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (clear_sr),
        .shift_en_i(shift_en),
        .bit_i     (sdata_i),
        .word_o    (word_w)
    );

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        shift_en = 1'b0;
        clear_sr = 1'b0;
        rise_nx  = q.rises + 1'b1;
        case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st     = ST_SETUP;
                    d.cs_n   = 1'b0;
                    d.tmr    = TMR_W'(CS_SETUP - 1);
                    d.half   = half_w;
                    d.rises  = '0;
                    clear_sr = 1'b1;
                end
            end
            ST_SETUP, ST_LO: begin
                if (q.tmr != '0) begin
                    d.tmr = q.tmr - 1'b1;
                end else if (q.st == ST_LO && q.rises == CNT_W'(FRAME_CLKS)) begin
                    // frame complete: present result and release the select
                    d.st     = ST_GAP;
                    d.cs_n   = 1'b1;
                    d.done   = 1'b1;
                    d.sample = word_w;
                    d.tmr    = TMR_W'(CS_HIGH - 1);
                    d.pend   = 1'b0;
                end else begin
                    d.st     = ST_HI;
                    d.sclk   = 1'b1;
                    d.tmr    = TMR_W'(q.half - 1'b1);
                    d.rises  = rise_nx;
                    shift_en = (rise_nx >= CNT_W'(FIRST_KEEP)) &&
                               (rise_nx <= CNT_W'(LAST_KEEP));
                end
            end
            ST_HI: begin
                if (q.tmr != '0) begin
                    d.tmr = q.tmr - 1'b1;
                end else begin
                    d.st   = ST_LO;
                    d.sclk = 1'b0;
                    d.tmr  = TMR_W'(q.half - 1'b1);
                end
            end
            ST_GAP: begin
                if (start_i) d.pend = 1'b1;
                if (q.tmr != '0) begin
                    d.tmr = q.tmr - 1'b1;
                end else if (q.pend || start_i) begin
                    d.st     = ST_SETUP;
                    d.cs_n   = 1'b0;
                    d.tmr    = TMR_W'(CS_SETUP - 1);
                    d.half   = half_w;
                    d.rises  = '0;
                    d.pend   = 1'b0;
                    clear_sr = 1'b1;
                end else begin
                    d.st = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st     <= ST_GAP;
            q.tmr    <= TMR_W'(CS_HIGH);
            q.rises  <= '0;
            q.half   <= DIV_W'(MIN_HALF);
            q.pend   <= 1'b0;
            q.cs_n   <= 1'b1;
            q.sclk   <= 1'b0;
            q.done   <= 1'b0;
            q.sample <= '0;
        end else begin
            q <= d;
        end
    end

    assign cs_n_o   = q.cs_n;
    assign sclk_o   = q.sclk;
    assign sample_o = q.sample;
    assign done_o   = q.done;

    // R6: done lasts a single cycle
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R6: the select only rises when a result is presented
    p_cs_rise_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |-> done_o);
    // R2: serial clock idles low outside a frame
    p_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o);
    // R2: edge count never exceeds the frame length
    p_rise_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q.rises <= CNT_W'(FRAME_CLKS));
    // R3: the half-period is frozen while the select is low
    p_half_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n_o && $past(!cs_n_o) |-> $stable(q.half));
endmodule

// File: tb/adc_rd_ctrl_tb.sv
module adc_rd_ctrl_tb_top;
    localparam int MIN_HALF = 28;
    localparam int MAX_HALF = 588;
    localparam int CS_SETUP = 10;
    localparam int CS_HIGH  = 58;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [9:0]  div_i = 10'd40;
    logic        sdata_i = 1'b0;
    logic        cs_n_o, sclk_o, done_o;
    logic [15:0] sample_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    adc_rd_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .div_i(div_i),
        .sdata_i(sdata_i), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
        .sample_o(sample_o), .done_o(done_o)
    );

    always #5 clk = ~clk;

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            summary();
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp_v, exp_v);
        end
    endtask

    // converter model: new bit after each falling serial-clock edge
    logic [12:0] code = '0;
    int          fall_n = 0;
    always @(negedge cs_n_o) begin
        fall_n  = 0;
        sdata_i <= ~code[12];
    end
    always @(negedge sclk_o) begin
        if (!cs_n_o) begin
            fall_n++;
            if (fall_n == 3)                      sdata_i <= code[12];
            else if (fall_n >= 4 && fall_n <= 15) sdata_i <= code[15-fall_n];
            else                                  sdata_i <= ~code[12];
        end
    end

    // waveform monitor, sampled away from the active edge
    int rises_m = 0, hi_min = 0, hi_max = 0, lo_min = 0, lo_max = 0;
    int setup_m = 0, gap_m = 0, cs_hi_cnt = 0, run_cnt = 0;
    logic sc_p = 1'b0, cs_p = 1'b1;
    always @(negedge clk) begin
        if (!cs_n_o) begin
            if (cs_p) begin
                rises_m = 0; hi_min = 1000000; hi_max = 0; lo_min = 1000000; lo_max = 0;
                gap_m = cs_hi_cnt; run_cnt = 1;
            end else if (sclk_o != sc_p) begin
                if (sc_p) begin
                    if (run_cnt < hi_min) hi_min = run_cnt;
                    if (run_cnt > hi_max) hi_max = run_cnt;
                end else if (rises_m == 0) begin
                    setup_m = run_cnt;
                end else begin
                    if (run_cnt < lo_min) lo_min = run_cnt;
                    if (run_cnt > lo_max) lo_max = run_cnt;
                end
                if (sclk_o) rises_m++;
                run_cnt = 1;
            end else begin
                run_cnt++;
            end
        end else begin
            if (!cs_p) begin
                if (run_cnt < lo_min) lo_min = run_cnt;
                if (run_cnt > lo_max) lo_max = run_cnt;
                cs_hi_cnt = 1;
            end else begin
                cs_hi_cnt++;
            end
            if (sclk_o) begin
                checks++; errors++;
                $display("FAIL R2: actual sclk 1 expected 0 while select high");
            end
        end
        sc_p = sclk_o;
        cs_p = cs_n_o;
    end

    function automatic int clamp_half(input int v);
        if (v < MIN_HALF) return MIN_HALF;
        if (v > MAX_HALF) return MAX_HALF;
        return v;
    endfunction

    task automatic wait_done();
        int n = 0;
        while (!done_o && n < 30000) begin
            @(negedge clk);
            n++;
        end
        chk(done_o == 1'b1, "R6 done seen", int'(done_o), 1);
    endtask

    task automatic check_frame(input logic [12:0] c, input int half);
        logic [15:0] exp_s;
        exp_s = {{3{c[12]}}, c};
        chk(sample_o == exp_s, "R5 R6 sample", int'(sample_o), int'(exp_s));
        chk(cs_n_o == 1'b1, "R6 select high at done", int'(cs_n_o), 1);
        chk(rises_m == 17, "R2 rising edges", rises_m, 17);
        chk(hi_min == half && hi_max == half, "R3 high phase", hi_max, half);
        chk(lo_min == half && lo_max == half, "R3 low phase", lo_max, half);
        chk(setup_m == CS_SETUP, "R4 setup", setup_m, CS_SETUP);
        @(negedge clk);
        chk(done_o == 1'b0, "R6 done single cycle", int'(done_o), 0);
        chk(sample_o == exp_s, "R6 sample held", int'(sample_o), int'(exp_s));
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(cs_n_o == 1'b1, "R1 cs_n", int'(cs_n_o), 1);
        chk(sclk_o == 1'b0, "R1 sclk", int'(sclk_o), 0);
        chk(done_o == 1'b0, "R1 done", int'(done_o), 0);
        chk(sample_o == 16'h0, "R1 sample", int'(sample_o), 0);
    endtask

    // R9: a start straight out of reset waits for the recovery interval
    task automatic t_start_after_reset(input logic [12:0] c);
        code  = c;
        div_i = 10'd40;
        rst_n = 1'b1; start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        repeat (CS_HIGH - 1) @(negedge clk);
        chk(cs_n_o == 1'b1, "R9 still high", int'(cs_n_o), 1);
        @(negedge clk);
        chk(cs_n_o == 1'b0, "R9 frame begins", int'(cs_n_o), 0);
        wait_done();
        check_frame(c, 40);
    endtask

    task automatic t_frame(input logic [12:0] c, input int div);
        code = c;
        div_i = 10'(div);
        repeat (CS_HIGH + 2) @(negedge clk);
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        wait_done();
        check_frame(c, clamp_half(div));
    endtask

    // R7: a start given during recovery is served after exactly CS_HIGH cycles
    task automatic t_back_to_back(input logic [12:0] c1, input logic [12:0] c2);
        code = c1; div_i = 10'd30;
        repeat (CS_HIGH + 2) @(negedge clk);
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        wait_done();
        check_frame(c1, 30);
        code = c2;
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        wait_done();
        chk(gap_m == CS_HIGH, "R7 recovery length", gap_m, CS_HIGH);
        check_frame(c2, 30);
    endtask

    // R3 and R8: divider change and extra start during a frame are ignored
    task automatic t_busy_ignore(input logic [12:0] c);
        int lows = 0;
        code = c; div_i = 10'd30;
        repeat (CS_HIGH + 2) @(negedge clk);
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        repeat (200) @(negedge clk);
        div_i = 10'd100;
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        wait_done();
        check_frame(c, 30);
        for (int i = 0; i < 3 * CS_HIGH; i++) begin
            @(negedge clk);
            if (!cs_n_o) lows++;
        end
        chk(lows == 0, "R8 no extra frame", lows, 0);
    endtask

    initial begin
        t_reset_state();
        t_start_after_reset(13'h0ABC);
        t_frame(13'h1F00, 3);      // below the lower limit
        t_frame(13'h0FFF, 40);     // largest positive
        t_frame(13'h1000, 28);     // most negative
        t_frame(13'h0000, 55);
        t_frame(13'h1FFF, 1000);   // above the upper limit
        t_frame(13'h1555, 33);
        t_back_to_back(13'h0A5A, 13'h15A5);
        t_busy_ignore(13'h0123);
        summary();
    end
endmodule